// File: doc/BRIEF.md
# Delegated Counter Indirect-Access Router

This block sits behind the supervisor indirect-CSR window and serves the part of the select space that exposes hardware performance counters to a supervisor. A select value from a base offset upward names one counter. The alias register used picks which word of that counter is reached: the count, its configuration/event word, or, on a 32-bit hart, the upper halves of either. The block routes each access onto the machine counter file. The file holds the actual state and answers reads combinationally. The block returns the supervisor view of the data and issues write strobes with per-counter masking.

Each counter is visible to the supervisor only when machine software has turned on delegation globally and has also set that counter's bit in the counter-enable mask. Every other access in the range raises an exception. The block applies a fixed priority to choose between illegal-instruction and virtual-instruction, and it covers the permanent hole at the second select slot. The machine-mode-inhibit bit of every event word is hidden from the supervisor and protected against supervisor writes. Select values outside the range are flagged as foreign, so that another handler can answer them.

Each access is presented for one cycle. The registered response, and any write toward the counter file, appear on the next clock edge.

Top module: `cdr_router`

## Requirements
- R1: A read or write strobe at a rising edge produces `rsp_valid` at the next edge, together with its result. A cycle with no strobe yields no response and no file write. Reset (synchronous, active low) clears every response and write output to zero.
- R2: A select outside 0x40..0x5F sets `rsp_notmine`, raises no exception, returns zero data and does not write.
- R3: Counter i (select 0x40+i) is delegated only when `deleg_en`=1 and `cnt_en_mask[i]`=1. An access to a counter that is not delegated is illegal.
- R4: Select 0x41 always raises illegal-instruction, whatever the mode, enables or alias register.
- R5: The counter index is select minus 0x40. The `req_alias` code maps to a file field on `fr_field`/`fw_field` as follows: code 1 gives the count low word or the full count (field 0); code 4 gives the count high word (field 1); code 2 gives the event word (field 2); code 5 gives the event high word (field 3).
- R6: Alias codes 0, 3, 6 and 7 are illegal. Codes 4 and 5 are illegal when `xlen64`=1.
- R7: For counters 0 and 2, fields 0 and 1 need `ext_cntr` and fields 2 and 3 need `ext_cfg`. For counters 3..31, fields 0, 1 and 2 need `ext_hpm`, and field 3 needs both `ext_hpm` and `ext_ovf`. A missing extension makes the access illegal.
- R8: Reads of field 2 with `xlen64`=1 return bit 62 as zero. Reads of field 3 with `xlen64`=0 return bit 30 (the same bit seen through the high word) as zero.
- R9: A write to those event views keeps the stored inhibit bit: `fw_data` carries the file's current value in that bit. In 32-bit mode `fw_data` and `rsp_rdata` have their upper 32 bits zero.
- R10: An in-range access with `deleg_en`=0 is illegal-instruction, even in virtual mode. With `deleg_en`=1, `ext_hyp`=1 and `virt_on`=1, the access raises virtual-instruction.
- R11: An access through a virtual-supervisor alias (`req_valias`=1) in this range is illegal from every mode.
- R12: Any exception forces `fw_en`=0 and `rsp_rdata`=0. Illegal and virtual flags are never both set.
- R13: Privilege encoding is 0 for user, 1 for supervisor and 3 for machine. A non-virtual user-mode access, or any access with privilege 2, is illegal. `virt_on` without `ext_hyp` is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_sel | input | 12 | Indirect select value |
| req_alias | input | 3 | Alias register code (1..6) |
| req_valias | input | 1 | Access uses the virtual-supervisor aliases |
| req_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualization mode active |
| deleg_en | input | 1 | Global counter-delegation enable |
| cnt_en_mask | input | 32 | Machine counter-enable mask |
| xlen64 | input | 1 | 1 for 64-bit mode |
| ext_cntr | input | 1 | Base cycle/instret counters present |
| ext_cfg | input | 1 | Cycle/instret config words present |
| ext_hpm | input | 1 | Programmable counters present |
| ext_ovf | input | 1 | Overflow extension (event high word) present |
| ext_hyp | input | 1 | Hypervisor extension present |
| fr_idx | output | 5 | Counter index presented to the file for reads |
| fr_field | output | 2 | Field presented to the file for reads |
| fr_rdata | input | 64 | File read data (in 32-bit mode, the addressed half in bits 31:0) |
| fw_en | output | 1 | File write strobe |
| fw_idx | output | 5 | File write counter index |
| fw_field | output | 2 | File write field |
| fw_data | output | 64 | File write data |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Supervisor view of the addressed word |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_virt | output | 1 | Virtual-instruction exception |
| rsp_notmine | output | 1 | Select not handled by this block |

## Verification
Some rules are checked by assertions on every cycle. Strobes always get a response, and idle cycles stay quiet. Exceptions suppress writes and data. The hole and the virtual-supervisor aliases are illegal, and so is any in-range access with delegation off. Foreign selects stay silent. A write never reaches a counter that is not delegated, and the 64-bit event view never shows the inhibit bit. Other behaviour shows up only in the bench's scenarios: the exact alias-to-field mapping, extension gating per counter class, and the precedence across the whole matrix. The same goes for write merging of the inhibit bit against stored contents, and for the 32-bit high-word views. These are compared against a reference model of the counter file.

// File: rtl/cdr_pkg.sv
// Shared types for the delegated counter router.
// Assumes: file fields and exception classes are closed sets.
package cdr_pkg;

    typedef enum logic [1:0] {
        FLD_LO   = 2'd0,
        FLD_HI   = 2'd1,
        FLD_CFG  = 2'd2,
        FLD_CFGH = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_VIRTUAL = 2'd2,
        EXC_FOREIGN = 2'd3
    } exc_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/cdr_sel_decode.sv
// Select and alias decoder.
// Checks whether a select falls in the counter window, extracts the counter
// index, flags the hole slot and maps the alias code onto a file field.
// Assumes: NCNT fits in IDX_W bits and the window does not wrap.
module cdr_sel_decode
    import cdr_pkg::*;
#(
    parameter int SEL_W    = 12,
    parameter int SEL_BASE = 'h40,
    parameter int NCNT     = 32,
    parameter int HOLE_IDX = 1,
    parameter int IDX_W    = $clog2(NCNT)
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [2:0]       alias_code,
    output logic             in_range,
    output logic             hole,
    output logic [IDX_W-1:0] idx,
    output fld_e             fld,
    output logic             alias_known,
    output logic             alias_upper
);

    localparam logic [SEL_W-1:0] BASE_V = SEL_W'(SEL_BASE);
    localparam logic [SEL_W-1:0] NCNT_V = SEL_W'(NCNT);
    localparam logic [IDX_W-1:0] HOLE_V = IDX_W'(HOLE_IDX);

    logic [SEL_W-1:0] offset;

    // Offset of the select from the window base.
    always_comb offset = sel - BASE_V;

    // Window membership, index extraction and hole detection.
    always_comb begin
        in_range = (sel >= BASE_V) && (offset < NCNT_V);
        idx      = offset[IDX_W-1:0];
        hole     = in_range && (idx == HOLE_V);
    end

    // Alias code to file field, with legality flags.
    always_comb begin
        fld         = FLD_LO;
        alias_known = 1'b0;
        alias_upper = 1'b0;
        unique case (alias_code)
            3'd1: begin fld = FLD_LO;   alias_known = 1'b1; end
            3'd2: begin fld = FLD_CFG;  alias_known = 1'b1; end
            3'd4: begin fld = FLD_HI;   alias_known = 1'b1; alias_upper = 1'b1; end
            3'd5: begin fld = FLD_CFGH; alias_known = 1'b1; alias_upper = 1'b1; end
            default: begin fld = FLD_LO; alias_known = 1'b0; end
        endcase
    end

endmodule

// File: rtl/cdr_exc_matrix.sv
// Exception matrix for the counter window.
// Builds the per-counter delegation vector and resolves the cause with a
// fixed priority: foreign, hole, virtual alias, delegation off, virtual
// mode, privilege, alias legality, counter delegation, extension presence.
// Assumes: counters FIX_A and FIX_B are the base counters, others are
// programmable.
module cdr_exc_matrix
    import cdr_pkg::*;
#(
    parameter int NCNT  = 32,
    parameter int FIX_A = 0,
    parameter int FIX_B = 2,
    parameter int IDX_W = $clog2(NCNT)
) (
    input  logic             in_range,
    input  logic             hole,
    input  logic             valias,
    input  logic             deleg_en,
    input  logic             virt_on,
    input  logic             ext_hyp,
    input  logic [1:0]       priv_lvl,
    input  logic             alias_known,
    input  logic             alias_upper,
    input  logic             xlen64,
    input  logic [NCNT-1:0]  cnt_en_mask,
    input  logic [IDX_W-1:0] idx,
    input  fld_e             fld,
    input  logic             ext_cntr,
    input  logic             ext_cfg,
    input  logic             ext_hpm,
    input  logic             ext_ovf,
    output exc_e             cause
);

    logic [NCNT-1:0] deleg_vec;
    logic            is_fixed;
    logic            ext_ok;
    logic            priv_ok;

    // One delegation bit per counter.
    generate
        for (genvar gi = 0; gi < NCNT; gi++) begin : g_deleg
            assign deleg_vec[gi] = deleg_en & cnt_en_mask[gi];
        end
    endgenerate

    // Classify the counter as base or programmable.
    always_comb is_fixed = (idx == IDX_W'(FIX_A)) || (idx == IDX_W'(FIX_B));

    // Extension presence needed for the addressed field.
    always_comb begin
        if (is_fixed) begin
            ext_ok = (fld == FLD_LO || fld == FLD_HI) ? ext_cntr : ext_cfg;
        end else begin
            ext_ok = (fld == FLD_CFGH) ? (ext_hpm & ext_ovf) : ext_hpm;
        end
    end

    // Non-virtual privilege must be supervisor or machine.
    always_comb priv_ok = (priv_lvl == PRIV_S) || (priv_lvl == PRIV_M);

    // Priority resolution of the exception cause.
    always_comb begin
        if (!in_range)                       cause = EXC_FOREIGN;
        else if (hole)                       cause = EXC_ILLEGAL;
        else if (valias)                     cause = EXC_ILLEGAL;
        else if (!deleg_en)                  cause = EXC_ILLEGAL;
        else if (virt_on && ext_hyp)         cause = EXC_VIRTUAL;
        else if (virt_on)                    cause = EXC_ILLEGAL;
        else if (!priv_ok)                   cause = EXC_ILLEGAL;
        else if (!alias_known)               cause = EXC_ILLEGAL;
        else if (alias_upper && xlen64)      cause = EXC_ILLEGAL;
        else if (!deleg_vec[idx])            cause = EXC_ILLEGAL;
        else if (!ext_ok)                    cause = EXC_ILLEGAL;
        else                                 cause = EXC_NONE;
    end

endmodule

// File: rtl/cdr_view_mask.sv
// Supervisor data view and write merge.
// Hides the machine-inhibit bit of event words in reads and carries the
// stored value of that bit into writes; narrows data in 32-bit mode.
// Assumes: in 32-bit mode the file returns the addressed half in the low
// word; MINH_BIT lies in the upper word.
module cdr_view_mask
    import cdr_pkg::*;
#(
    parameter int DW       = 64,
    parameter int MINH_BIT = 62
) (
    input  fld_e          fld,
    input  logic          xlen64,
    input  logic [DW-1:0] fr_rdata,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rview,
    output logic [DW-1:0] wmerge
);

    localparam int HALF    = DW / 2;
    localparam int MINH_HI = MINH_BIT - HALF;

    logic [DW-1:0] rd_narrow;
    logic [DW-1:0] wr_narrow;
    logic          mask_wide;
    logic          mask_half;

    // Narrow both directions to the low half in 32-bit mode.
    always_comb begin
        rd_narrow = xlen64 ? fr_rdata : {{HALF{1'b0}}, fr_rdata[HALF-1:0]};
        wr_narrow = xlen64 ? wdata    : {{HALF{1'b0}}, wdata[HALF-1:0]};
    end

    // Select which inhibit position applies to this view.
    always_comb begin
        mask_wide = xlen64  && (fld == FLD_CFG);
        mask_half = !xlen64 && (fld == FLD_CFGH);
    end

    // Clear the inhibit bit on reads, keep the stored one on writes.
    always_comb begin
        rview  = rd_narrow;
        wmerge = wr_narrow;
        if (mask_wide) begin
            rview[MINH_BIT]  = 1'b0;
            wmerge[MINH_BIT] = fr_rdata[MINH_BIT];
        end
        if (mask_half) begin
            rview[MINH_HI]  = 1'b0;
            wmerge[MINH_HI] = fr_rdata[MINH_HI];
        end
    end

endmodule

// File: rtl/cdr_router.sv
// Delegated counter indirect-access router (top).
// Decodes one supervisor indirect access per cycle, looks the addressed
// word up in the machine counter file combinationally and registers the
// response and any file write for the next edge.
// Assumes: the counter file answers fr_idx/fr_field in the same cycle and
// applies fw_* at the edge after it is asserted.
module cdr_router
    import cdr_pkg::*;
#(
    parameter int SEL_W    = 12,
    parameter int SEL_BASE = 'h40,
    parameter int NCNT     = 32,
    parameter int DW       = 64,
    parameter int MINH_BIT = 62,
    parameter int IDX_W    = $clog2(NCNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_rd,
    input  logic             req_wr,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [2:0]       req_alias,
    input  logic             req_valias,
    input  logic [DW-1:0]    req_wdata,
    input  logic [1:0]       priv_lvl,
    input  logic             virt_on,
    input  logic             deleg_en,
    input  logic [NCNT-1:0]  cnt_en_mask,
    input  logic             xlen64,
    input  logic             ext_cntr,
    input  logic             ext_cfg,
    input  logic             ext_hpm,
    input  logic             ext_ovf,
    input  logic             ext_hyp,
    output logic [IDX_W-1:0] fr_idx,
    output logic [1:0]       fr_field,
    input  logic [DW-1:0]    fr_rdata,
    output logic             fw_en,
    output logic [IDX_W-1:0] fw_idx,
    output logic [1:0]       fw_field,
    output logic [DW-1:0]    fw_data,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_illegal,
    output logic             rsp_virt,
    output logic             rsp_notmine
);

    logic             in_range;
    logic             hole;
    logic [IDX_W-1:0] idx;
    fld_e             fld;
    logic             alias_known;
    logic             alias_upper;
    exc_e             cause;
    logic [DW-1:0]    rview;
    logic [DW-1:0]    wmerge;
    logic             access;
    logic             accept;

    cdr_sel_decode #(
        .SEL_W    (SEL_W),
        .SEL_BASE (SEL_BASE),
        .NCNT     (NCNT),
        .HOLE_IDX (1),
        .IDX_W    (IDX_W)
    ) u_dec (
        .sel         (req_sel),
        .alias_code  (req_alias),
        .in_range    (in_range),
        .hole        (hole),
        .idx         (idx),
        .fld         (fld),
        .alias_known (alias_known),
        .alias_upper (alias_upper)
    );

    cdr_exc_matrix #(
        .NCNT  (NCNT),
        .FIX_A (0),
        .FIX_B (2),
        .IDX_W (IDX_W)
    ) u_exc (
        .in_range    (in_range),
        .hole        (hole),
        .valias      (req_valias),
        .deleg_en    (deleg_en),
        .virt_on     (virt_on),
        .ext_hyp     (ext_hyp),
        .priv_lvl    (priv_lvl),
        .alias_known (alias_known),
        .alias_upper (alias_upper),
        .xlen64      (xlen64),
        .cnt_en_mask (cnt_en_mask),
        .idx         (idx),
        .fld         (fld),
        .ext_cntr    (ext_cntr),
        .ext_cfg     (ext_cfg),
        .ext_hpm     (ext_hpm),
        .ext_ovf     (ext_ovf),
        .cause       (cause)
    );

    cdr_view_mask #(
        .DW       (DW),
        .MINH_BIT (MINH_BIT)
    ) u_view (
        .fld      (fld),
        .xlen64   (xlen64),
        .fr_rdata (fr_rdata),
        .wdata    (req_wdata),
        .rview    (rview),
        .wmerge   (wmerge)
    );

    // Present the decoded address to the counter file for lookup.
    always_comb begin
        fr_idx   = idx;
        fr_field = fld;
    end

    // Qualify the access and whether it completes without exception.
    always_comb begin
        access = req_rd | req_wr;
        accept = access && (cause == EXC_NONE);
    end

    // Register the response and the file write for the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_illegal <= 1'b0;
            rsp_virt    <= 1'b0;
            rsp_notmine <= 1'b0;
            fw_en       <= 1'b0;
            fw_idx      <= '0;
            fw_field    <= '0;
            fw_data     <= '0;
        end else begin
            rsp_valid   <= access;
            rsp_rdata   <= accept ? rview : '0;
            rsp_illegal <= access && (cause == EXC_ILLEGAL);
            rsp_virt    <= access && (cause == EXC_VIRTUAL);
            rsp_notmine <= access && (cause == EXC_FOREIGN);
            fw_en       <= accept && req_wr;
            fw_idx      <= idx;
            fw_field    <= fld;
            fw_data     <= wmerge;
        end
    end

endmodule

// File: rtl/cdr_router_chk.sv
// Property checker for cdr_router, attached by bind below.
// Assumes: the default window 0x40..0x5F with the hole at 0x41 and
// the inhibit bit at 62.
module cdr_router_chk #(
    parameter int SEL_W    = 12,
    parameter int SEL_BASE = 'h40,
    parameter int NCNT     = 32,
    parameter int DW       = 64,
    parameter int MINH_BIT = 62
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_rd,
    input logic             req_wr,
    input logic [SEL_W-1:0] req_sel,
    input logic [2:0]       req_alias,
    input logic             req_valias,
    input logic             deleg_en,
    input logic [NCNT-1:0]  cnt_en_mask,
    input logic             xlen64,
    input logic             fw_en,
    input logic             rsp_valid,
    input logic [DW-1:0]    rsp_rdata,
    input logic             rsp_illegal,
    input logic             rsp_virt,
    input logic             rsp_notmine
);

    localparam logic [SEL_W-1:0] BASE_V = SEL_W'(SEL_BASE);
    localparam logic [SEL_W-1:0] HOLE_V = SEL_W'(SEL_BASE + 1);
    localparam logic [SEL_W-1:0] TOP_V  = SEL_W'(SEL_BASE + NCNT);

    logic             acc;
    logic             win;
    logic [SEL_W-1:0] off;
    logic             cnt_off;

    // Derived request conditions observed at the ports.
    always_comb begin
        acc     = req_rd | req_wr;
        win     = (req_sel >= BASE_V) && (req_sel < TOP_V);
        off     = req_sel - BASE_V;
        cnt_off = win ? !cnt_en_mask[off[$clog2(NCNT)-1:0]] : 1'b0;
    end

    assert_resp_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!rsp_valid && !fw_en));
    assert_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !win) |=> (rsp_notmine && !rsp_illegal && !rsp_virt && !fw_en && rsp_rdata == '0));
    assert_no_deleg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && cnt_off) |=> !fw_en);
    assert_hole_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_sel == HOLE_V) |=> (rsp_illegal && !rsp_virt));
    assert_minh_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win && xlen64 && req_alias == 3'd2) |=> !rsp_rdata[MINH_BIT]);
    assert_cde_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win && !deleg_en) |=> (rsp_illegal && !rsp_virt));
    assert_valias_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win && req_valias) |=> rsp_illegal);
    assert_exc_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_illegal || rsp_virt) |-> (!fw_en && rsp_rdata == '0));
    assert_exc_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_illegal, rsp_virt, rsp_notmine}));

endmodule

bind cdr_router cdr_router_chk #(
    .SEL_W    (SEL_W),
    .SEL_BASE (SEL_BASE),
    .NCNT     (NCNT),
    .DW       (DW),
    .MINH_BIT (MINH_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_rd      (req_rd),
    .req_wr      (req_wr),
    .req_sel     (req_sel),
    .req_alias   (req_alias),
    .req_valias  (req_valias),
    .deleg_en    (deleg_en),
    .cnt_en_mask (cnt_en_mask),
    .xlen64      (xlen64),
    .fw_en       (fw_en),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal),
    .rsp_virt    (rsp_virt),
    .rsp_notmine (rsp_notmine)
);

// File: tb/cdr_router_tb.sv
module cdr_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 0, req_wr = 0;
    logic [11:0] req_sel = '0;
    logic [2:0]  req_alias = '0;
    logic        req_valias = 0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  priv_lvl = 2'd1;
    logic        virt_on = 0, deleg_en = 0;
    logic [31:0] cnt_en_mask = '0;
    logic        xlen64 = 1;
    logic        ext_cntr = 1, ext_cfg = 1, ext_hpm = 1, ext_ovf = 1, ext_hyp = 1;
    logic [4:0]  fr_idx, fw_idx;
    logic [1:0]  fr_field, fw_field;
    logic [63:0] fr_rdata, fw_data, rsp_rdata;
    logic        fw_en, rsp_valid, rsp_illegal, rsp_virt, rsp_notmine;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [63:0] m_cnt [32];
    logic [63:0] m_cfg [32];

    always #2 clk = ~clk;

    cdr_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_sel(req_sel), .req_alias(req_alias), .req_valias(req_valias),
        .req_wdata(req_wdata), .priv_lvl(priv_lvl), .virt_on(virt_on),
        .deleg_en(deleg_en), .cnt_en_mask(cnt_en_mask), .xlen64(xlen64),
        .ext_cntr(ext_cntr), .ext_cfg(ext_cfg), .ext_hpm(ext_hpm),
        .ext_ovf(ext_ovf), .ext_hyp(ext_hyp), .fr_idx(fr_idx),
        .fr_field(fr_field), .fr_rdata(fr_rdata), .fw_en(fw_en),
        .fw_idx(fw_idx), .fw_field(fw_field), .fw_data(fw_data),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_illegal(rsp_illegal), .rsp_virt(rsp_virt),
        .rsp_notmine(rsp_notmine)
    );

    // Counter file model: word as the file presents it.
    function automatic logic [63:0] mread(input logic [4:0] i, input logic [1:0] f, input logic x64);
        case (f)
            2'd0:    return x64 ? m_cnt[i] : {32'd0, m_cnt[i][31:0]};
            2'd1:    return {32'd0, m_cnt[i][63:32]};
            2'd2:    return x64 ? m_cfg[i] : {32'd0, m_cfg[i][31:0]};
            default: return {32'd0, m_cfg[i][63:32]};
        endcase
    endfunction

    assign fr_rdata = mread(fr_idx, fr_field, xlen64);

    // Counter file model: initial contents and write port.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                m_cnt[i] <= {32'hC0DE0000 + 32'(i), 32'h00001000 + 32'(i * 7)};
                m_cfg[i] <= 64'h4000_0000_4000_0000 | 64'(i * 'h111);
            end
        end else if (fw_en) begin
            case (fw_field)
                2'd0: if (xlen64) m_cnt[fw_idx] <= fw_data; else m_cnt[fw_idx][31:0] <= fw_data[31:0];
                2'd1: m_cnt[fw_idx][63:32] <= fw_data[31:0];
                2'd2: if (xlen64) m_cfg[fw_idx] <= fw_data; else m_cfg[fw_idx][31:0] <= fw_data[31:0];
                default: m_cfg[fw_idx][63:32] <= fw_data[31:0];
            endcase
        end
    end

    // Expected cause: 0 none, 1 illegal, 2 virtual, 3 foreign; tag names the rule.
    function automatic int exp_cause(output string tag);
        int i;
        logic [1:0] f;
        bit known, upper, fixed, extok;
        i = int'(req_sel) - 'h40;
        known = (req_alias == 1 || req_alias == 2 || req_alias == 4 || req_alias == 5);
        upper = (req_alias == 4 || req_alias == 5);
        f = (req_alias == 4) ? 2'd1 : (req_alias == 2) ? 2'd2 : (req_alias == 5) ? 2'd3 : 2'd0;
        if (i < 0 || i >= 32) begin tag = "R2"; return 3; end
        if (i == 1)           begin tag = "R4"; return 1; end
        if (req_valias)       begin tag = "R11"; return 1; end
        if (!deleg_en)        begin tag = "R10"; return 1; end
        if (virt_on && ext_hyp) begin tag = "R10"; return 2; end
        if (virt_on)          begin tag = "R13"; return 1; end
        if (priv_lvl == 0 || priv_lvl == 2) begin tag = "R13"; return 1; end
        if (!known || (upper && xlen64)) begin tag = "R6"; return 1; end
        if (!cnt_en_mask[i])  begin tag = "R3"; return 1; end
        fixed = (i == 0 || i == 2);
        if (fixed) extok = (f < 2) ? ext_cntr : ext_cfg;
        else       extok = (f == 3) ? (ext_hpm && ext_ovf) : ext_hpm;
        if (!extok)           begin tag = "R7"; return 1; end
        tag = "R5";
        return 0;
    endfunction

    // Issue one access, compare the registered response, leave one idle cycle.
    task automatic access(input bit rd, input bit wr);
        int cause;
        string tag;
        logic [63:0] e_rd, e_wd, cur;
        logic [4:0] e_idx;
        logic [1:0] e_f;
        bit e_fwen, bad;
        req_rd = rd; req_wr = wr;
        cause = exp_cause(tag);
        e_idx = req_sel[4:0] - 5'h0;
        e_idx = 5'(int'(req_sel) - 'h40);
        e_f = (req_alias == 4) ? 2'd1 : (req_alias == 2) ? 2'd2 : (req_alias == 5) ? 2'd3 : 2'd0;
        cur = mread(e_idx, e_f, xlen64);
        e_rd = cur;
        e_wd = xlen64 ? req_wdata : {32'd0, req_wdata[31:0]};
        if (e_f == 2 && xlen64)  begin e_rd[62] = 1'b0; e_wd[62] = cur[62]; tag = {tag, "/R8/R9"}; end
        if (e_f == 3 && !xlen64) begin e_rd[30] = 1'b0; e_wd[30] = cur[30]; tag = {tag, "/R8/R9"}; end
        if (cause != 0) begin e_rd = '0; tag = {tag, "/R12"}; end
        e_fwen = (cause == 0) && wr;
        @(posedge clk);
        @(negedge clk);
        checks++;
        bad = (rsp_valid != (rd | wr)) || (rsp_illegal != (cause == 1)) ||
              (rsp_virt != (cause == 2)) || (rsp_notmine != (cause == 3)) ||
              (rsp_rdata != e_rd) || (fw_en != e_fwen) ||
              (e_fwen && (fw_idx != e_idx || fw_field != e_f || fw_data != e_wd));
        if (bad) begin
            errors++;
            $display("FAIL %s R1 sel=%h alias=%0d: got v=%b ill=%b vi=%b nm=%b rd=%h we=%b wi=%0d wf=%0d wd=%h exp ill=%b vi=%b nm=%b rd=%h we=%b wi=%0d wf=%0d wd=%h",
                     tag, req_sel, req_alias, rsp_valid, rsp_illegal, rsp_virt, rsp_notmine,
                     rsp_rdata, fw_en, fw_idx, fw_field, fw_data,
                     cause == 1, cause == 2, cause == 3, e_rd, e_fwen, e_idx, e_f, e_wd);
        end
        req_rd = 0; req_wr = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setup_ok();
        deleg_en = 1; cnt_en_mask = 32'hFFFF_FFFF; priv_lvl = 2'd1; virt_on = 0;
        req_valias = 0; xlen64 = 1;
        ext_cntr = 1; ext_cfg = 1; ext_hpm = 1; ext_ovf = 1; ext_hyp = 1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog R1: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        checks++;
        if (rsp_valid || fw_en || rsp_illegal || rsp_virt || rsp_notmine || rsp_rdata != 0) begin
            errors++;
            $display("FAIL R1 reset: got v=%b we=%b ill=%b vi=%b nm=%b expected all zero",
                     rsp_valid, fw_en, rsp_illegal, rsp_virt, rsp_notmine);
        end
        rst_n = 1;
        @(negedge clk);

        // Directed corners.
        setup_ok();
        req_sel = 12'h045; req_alias = 1; access(1, 0);            // R5 low word read
        req_sel = 12'h041; req_alias = 1; access(1, 1);            // R4 hole, R12 no write
        req_sel = 12'h03F; access(1, 0);                           // R2 below window
        req_sel = 12'h060; access(0, 1);                           // R2 above window
        req_sel = 12'h047; req_alias = 2; access(1, 0);            // R8 wide inhibit hidden
        req_wdata = 64'h0123_4567_89AB_CDEF; access(0, 1);         // R9 write merge (bit 62 clear in data)
        req_wdata = 64'hFFFF_FFFF_FFFF_FFFF; access(0, 1);         // R9 write merge (bit 62 set)
        req_alias = 4; access(1, 0);                               // R6 high word under 64-bit
        req_alias = 3; access(1, 0);                               // R6 unused alias
        xlen64 = 0; req_alias = 5; access(1, 0);                   // R8 half-width inhibit hidden
        req_wdata = 64'h0; access(0, 1);                           // R9 half-width merge
        req_alias = 4; req_wdata = 64'hAAAA_5555_1234_5678; access(0, 1); // R5 high-word write
        xlen64 = 1;
        cnt_en_mask[9] = 0; req_sel = 12'h049; req_alias = 1; access(1, 1); // R3 not delegated
        cnt_en_mask[9] = 1;
        deleg_en = 0; virt_on = 1; access(1, 0);                   // R10 illegal beats virtual
        deleg_en = 1; access(1, 0);                                // R10 virtual
        ext_hyp = 0; access(1, 0);                                 // R13 virtual without hypervisor
        ext_hyp = 1; virt_on = 0;
        req_valias = 1; priv_lvl = 2'd3; access(1, 0);             // R11 virtual alias from machine
        req_valias = 0; priv_lvl = 2'd0; access(1, 0);             // R13 user mode
        priv_lvl = 2'd1; ext_cfg = 0; req_sel = 12'h040; req_alias = 2; access(1, 0); // R7 config absent
        ext_cfg = 1; ext_ovf = 0; xlen64 = 0; req_sel = 12'h050; req_alias = 5; access(1, 0); // R7 overflow absent
        setup_ok();

        // Constrained random mix.
        for (int n = 0; n < 4000; n++) begin
            req_sel     = 12'h038 + 12'($urandom_range(0, 42));
            req_alias   = 3'($urandom_range(0, 7));
            req_valias  = ($urandom_range(0, 15) == 0);
            req_wdata   = {$urandom, $urandom};
            deleg_en    = ($urandom_range(0, 9) != 0);
            cnt_en_mask = $urandom | $urandom;
            xlen64      = 1'($urandom_range(0, 1));
            ext_cntr    = ($urandom_range(0, 9) != 0);
            ext_cfg     = ($urandom_range(0, 9) != 0);
            ext_hpm     = ($urandom_range(0, 9) != 0);
            ext_ovf     = ($urandom_range(0, 9) != 0);
            ext_hyp     = ($urandom_range(0, 9) != 0);
            case ($urandom_range(0, 2))
                0: priv_lvl = 2'd0;
                1: priv_lvl = 2'd1;
                default: priv_lvl = 2'd3;
            endcase
            virt_on = (priv_lvl != 2'd3) && ($urandom_range(0, 6) == 0);
            case ($urandom_range(0, 3))
                0: access(1, 0);
                1: access(0, 1);
                2: access(1, 1);
                default: begin
                    // R1: an idle cycle produces nothing.
                    @(posedge clk); @(negedge clk);
                    checks++;
                    if (rsp_valid || fw_en) begin
                        errors++;
                        $display("FAIL R1 idle: got v=%b we=%b expected 0 0", rsp_valid, fw_en);
                    end
                end
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule